// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel 10-bit converter. A host sends 16-bit command words over a three-wire serial link: an active-low select that also acts as a load strobe, a serial clock and a data line. While select is low, each rising serial-clock edge shifts one bit into a word register. When select returns high, the block decodes the 4-bit command at the head of the word. The command then acts on two buffered register pairs and a sleep flag.

Each channel has a staging register, loaded by commands, and an output register that drives the converter. Both output registers are always refreshed together from the staging registers, so the two channels change in the same clock cycle. The sleep indicator tells the analog section to power down. Sleep keeps every register, and staging registers can still be loaded while the block sleeps. A word that was not exactly 16 serial-clock edges long is dropped, and a one-cycle error pulse reports it. The three serial inputs are synchronised into the system clock domain, which must run at least four times faster than the serial clock.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset, both output codes are 0, the sleep indicator is 0 and the frame-error pulse is 0.
- R2: A word is taken MSB first. The first 4 bits form the command (word bits 15:12), the next 10 bits the data code (bits 11:2, data MSB first), and the last 2 bits are ignored.
- R3: Serial-clock edges while select is high shift nothing and count toward no word.
- R4: Outputs do not change while a word is being shifted. A command acts only after select rises, and both output codes change in the same cycle.
- R5: Command 0001 loads staging A only, and command 0010 loads staging B only. Neither changes the output codes or the sleep indicator.
- R6: Command 1000 copies both staging registers to the outputs and clears sleep.
- R7: Command 1001 loads staging A, and command 1010 loads staging B, with the new data. Each then copies both staging registers to the outputs (the new data included) and clears sleep.
- R8: Command 1111 loads the same data into both staging registers, copies both to the outputs and clears sleep.
- R9: Command 1110 sets sleep, ignores its data field and leaves all four registers unchanged. Staging registers stay loadable while asleep.
- R10: Commands 0000, 0011 to 0111, 1011, 1100 and 1101 change no register and no sleep state.
- R11: If select rises after any count of serial-clock edges other than 16, the word is discarded and frame_err_o is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Select / load strobe, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| code_a_o | output | 10 | Output code for channel A |
| code_b_o | output | 10 | Output code for channel B |
| asleep_o | output | 1 | Sleep indicator for the analog section |
| frame_err_o | output | 1 | One-cycle pulse when a word of the wrong length is dropped |

## Verification
The hardest state to reach from the ports is a staging register that differs from its output register, because staging contents cannot be read directly. The stimulus loads staging registers with distinct patterns during sleep, after no-op commands and around dropped short and long words. It then issues a bare update command, which exposes what each staging register held. Extra serial-clock pulses with select high come before a valid word, so that any miscounted edge shows up as a frame error or as shifted data.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned CMD_W = 4;

  localparam logic [CMD_W-1:0] OP_LD_A      = 4'b0001;
  localparam logic [CMD_W-1:0] OP_LD_B      = 4'b0010;
  localparam logic [CMD_W-1:0] OP_UPD       = 4'b1000;
  localparam logic [CMD_W-1:0] OP_LD_A_UPD  = 4'b1001;
  localparam logic [CMD_W-1:0] OP_LD_B_UPD  = 4'b1010;
  localparam logic [CMD_W-1:0] OP_SLEEP     = 4'b1110;
  localparam logic [CMD_W-1:0] OP_LD_AB_UPD = 4'b1111;

  typedef struct packed {
    logic ld_a;
    logic ld_b;
    logic upd;
    logic go_sleep;
  } dacfe_act_t;

  function automatic dacfe_act_t dacfe_decode(input logic [CMD_W-1:0] op);
    dacfe_act_t a;
    a = '0;
    case (op)
      OP_LD_A:      a.ld_a = 1'b1;
      OP_LD_B:      a.ld_b = 1'b1;
      OP_UPD:       a.upd = 1'b1;
      OP_LD_A_UPD:  begin a.ld_a = 1'b1; a.upd = 1'b1; end
      OP_LD_B_UPD:  begin a.ld_b = 1'b1; a.upd = 1'b1; end
      OP_SLEEP:     a.go_sleep = 1'b1;
      OP_LD_AB_UPD: begin a.ld_a = 1'b1; a.ld_b = 1'b1; a.upd = 1'b1; end
      default:      a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_n;

  always_comb pipe_n = {pipe_q[STAGES-1:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
    else        pipe_q <= pipe_n;
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_lvl_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  edges_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] word_q, word_n;
  logic [CNT_W-1:0]  edges_q, edges_n;
  logic              shift_en;

  always_comb begin
    shift_en = ~sel_lvl_i & sclk_rise_i;
    word_n   = word_q;
    edges_n  = edges_q;
    if (sel_lvl_i) begin
      edges_n = '0;
    end else if (shift_en) begin
      word_n = {word_q[WORD_W-2:0], sdi_lvl_i};
      if (edges_q != CNT_SAT) edges_n = edges_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      edges_q <= '0;
    end else begin
      word_q  <= word_n;
      edges_q <= edges_n;
    end
  end

  assign word_o  = word_q;
  assign edges_o = edges_q;

  // R3
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl_i |=> $stable(word_q));

  // R11
  edge_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edges_q <= CNT_SAT);
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [CMD_W-1:0]  op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o,
  output logic              asleep_o
);
  logic [DATA_W-1:0] stg_a_q, stg_a_n, stg_b_q, stg_b_n;
  logic [DATA_W-1:0] out_a_q, out_a_n, out_b_q, out_b_n;
  logic              slp_q, slp_n;
  dacfe_act_t        act;

  always_comb begin
    act     = dacfe_decode(op_i);
    stg_a_n = stg_a_q;
    stg_b_n = stg_b_q;
    out_a_n = out_a_q;
    out_b_n = out_b_q;
    slp_n   = slp_q;
    if (exec_i) begin
      if (act.ld_a) stg_a_n = data_i;
      if (act.ld_b) stg_b_n = data_i;
      if (act.upd) begin
        out_a_n = stg_a_n;
        out_b_n = stg_b_n;
        slp_n   = 1'b0;
      end
      if (act.go_sleep) slp_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a_q <= '0;
      stg_b_q <= '0;
      out_a_q <= '0;
      out_b_q <= '0;
      slp_q   <= 1'b0;
    end else begin
      stg_a_q <= stg_a_n;
      stg_b_q <= stg_b_n;
      out_a_q <= out_a_n;
      out_b_q <= out_b_n;
      slp_q   <= slp_n;
    end
  end

  assign out_a_o  = out_a_q;
  assign out_b_o  = out_b_q;
  assign asleep_o = slp_q;

  // R4
  hold_between_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(out_a_q) && $stable(out_b_q) && $stable(slp_q));

  // R9
  sleep_keeps_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_SLEEP) |=> slp_q && $stable(out_a_q) && $stable(out_b_q)
      && $stable(stg_a_q) && $stable(stg_b_q));

  // R5
  load_only_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == OP_LD_A || op_i == OP_LD_B)) |=>
      $stable(out_a_q) && $stable(out_b_q) && $stable(slp_q));

  // R6
  update_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OP_UPD) |=> !slp_q && out_a_q == $past(stg_a_q)
      && out_b_q == $past(stg_b_q));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned PAD_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic              asleep_o,
  output logic              frame_err_o
);
  localparam int unsigned WORD_W = CMD_W + DATA_W + PAD_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 2);

  logic              sel_lvl, sel_rise;
  logic              sclk_lvl, sclk_rise;
  logic              sdi_lvl, sdi_rise;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  edges;
  logic              full_word, exec, bad_frame;
  logic              err_q, err_n;

  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d_i(sel_n_i), .lvl_o(sel_lvl), .rise_o(sel_rise));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .lvl_o(sclk_lvl), .rise_o(sclk_rise));
  dacfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d_i(sdi_i), .lvl_o(sdi_lvl), .rise_o(sdi_rise));

  dacfe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_lvl_i(sel_lvl), .sclk_rise_i(sclk_rise),
    .sdi_lvl_i(sdi_lvl), .word_o(word), .edges_o(edges));

  always_comb begin
    full_word = (edges == CNT_W'(WORD_W));
    exec      = sel_rise & full_word;
    bad_frame = sel_rise & ~full_word;
    err_n     = bad_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  dacfe_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .exec_i(exec),
    .op_i(word[WORD_W-1 -: CMD_W]), .data_i(word[PAD_W +: DATA_W]),
    .out_a_o(code_a_o), .out_b_o(code_b_o), .asleep_o(asleep_o));

  assign frame_err_o = err_q;

  // R11
  bad_frame_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |=> frame_err_o && $stable(code_a_o) && $stable(code_b_o) && $stable(asleep_o));

  // R11
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  // R4
  no_exec_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_lvl |=> $stable(code_a_o) && $stable(code_b_o));
endmodule

// File: tb/dual_dac_frontend_tb.sv
module dual_dac_frontend_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_n, sclk, sdi;
  logic [9:0] code_a, code_b;
  logic       asleep, frame_err;

  always #2 clk = ~clk;

  dual_dac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .asleep_o(asleep), .frame_err_o(frame_err));

  typedef struct packed {
    logic [9:0]  a;
    logic [9:0]  b;
    logic        s;
    logic [15:0] e;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  int    err_cycles = 0;

  // reference model
  logic [9:0]  m_sa, m_sb, m_oa, m_ob;
  logic        m_slp;
  logic [15:0] m_err;

  always @(posedge clk) if (rst_n && frame_err) err_cycles++;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, "code_a", int'(code_a), int'(e.a));
        cmp(t, "code_b", int'(code_b), int'(e.b));
        cmp(t, "asleep", int'(asleep), int'(e.s));
        cmp(t, "frame_err count", err_cycles, int'(e.e));
      end
    end
  end

  task automatic push_exp(input string tag);
    exp_q.push_back('{a: m_oa, b: m_ob, s: m_slp, e: m_err});
    tag_q.push_back(tag);
    ->chk_ev;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(input logic bitv);
    sdi = bitv; waitc(3);
    sclk = 1'b1; waitc(3);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n, input string tag);
    sel_n = 1'b0; waitc(3);
    for (int i = n - 1; i >= 0; i--) sclk_pulse(bits[i]);
    waitc(3);
    push_exp("R4");
    sel_n = 1'b1;
    waitc(8);
  endtask

  task automatic model(input logic [3:0] op, input logic [9:0] d);
    case (op)
      4'b0001: m_sa = d;
      4'b0010: m_sb = d;
      4'b1000: begin m_oa = m_sa; m_ob = m_sb; m_slp = 1'b0; end
      4'b1001: begin m_sa = d; m_oa = m_sa; m_ob = m_sb; m_slp = 1'b0; end
      4'b1010: begin m_sb = d; m_oa = m_sa; m_ob = m_sb; m_slp = 1'b0; end
      4'b1110: m_slp = 1'b1;
      4'b1111: begin m_sa = d; m_sb = d; m_oa = d; m_ob = d; m_slp = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic cmd(input logic [3:0] op, input logic [9:0] d, input string tag);
    logic [15:0] w;
    w = {op, d, 2'b10};
    send_bits({16'h0, w}, 16, tag);
    model(op, d);
    push_exp(tag);
  endtask

  task automatic bad_word(input int n, input string tag);
    logic [15:0] w;
    w = {4'b1111, 10'h2E7, 2'b01};
    if (n == 15) send_bits({17'h0, w[15:1]}, 15, tag);
    else         send_bits({15'h0, w, 1'b1}, 17, tag);
    m_err++;
    push_exp(tag);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    m_sa = '0; m_sb = '0; m_oa = '0; m_ob = '0; m_slp = 1'b0; m_err = '0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    push_exp("R1");

    cmd(4'b0001, 10'h155, "R5");
    cmd(4'b1000, 10'h3FF, "R6");
    cmd(4'b0010, 10'h2AA, "R5");
    cmd(4'b1010, 10'h0F0, "R7");
    cmd(4'b1001, 10'h301, "R2");
    cmd(4'b1001, 10'h3FF, "R7");
    cmd(4'b1111, 10'h001, "R8");
    cmd(4'b1110, 10'h123, "R9");
    cmd(4'b0001, 10'h200, "R9");
    cmd(4'b0010, 10'h0AA, "R9");
    cmd(4'b1000, 10'h000, "R6");
    cmd(4'b1110, 10'h3C3, "R9");
    cmd(4'b1111, 10'h18C, "R8");

    foreach (tag_q[i]) ;
    cmd(4'b0001, 10'h11E, "R5");
    cmd(4'b0010, 10'h2E1, "R5");
    cmd(4'b0000, 10'h3C3, "R10");
    for (int op = 3; op <= 13; op++) begin
      if (op == 8 || op == 9 || op == 10) continue;
      cmd(4'(op), 10'h3C3, "R10");
    end
    cmd(4'b1000, 10'h000, "R10");

    cmd(4'b0001, 10'h0C5, "R5");
    bad_word(15, "R11");
    bad_word(17, "R11");
    cmd(4'b1000, 10'h000, "R11");

    for (int k = 0; k < 5; k++) sclk_pulse(k[0]);
    waitc(6);
    cmd(4'b1001, 10'h07E, "R3");
    push_exp("R3");

    waitc(10);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule